// File: doc/BRIEF.md
# Stream Index Predictor Compressor

This block is a second-stage compressor for the 8-bit index symbols that a stream cache produces. It keeps the previous index as a one-deep history and uses it to address a table of 256 one-byte entries. Each entry holds the index that most recently followed that history value. Every incoming symbol yields one verdict bit. The bit is 1 when the table predicted the symbol and 0 when it did not. On a wrong prediction the full symbol also leaves on a separate miss output, and the table entry is trained with it.

Verdict bits are packed into bytes, first symbol in the most significant bit. A steady stream of correct predictions therefore shows up as a run of 0xFF bytes, which suits a later run-length stage. A flush request pushes out a partly filled byte, left-aligned and padded with zeros. The block takes one symbol per clock and never stalls. Both outputs are registered and appear one cycle after the symbol is accepted.

Top module: `sidx_pred_pack`

## Requirements
- R1: Reset sets the history to 0, sets every table entry to 0, discards any pending verdict bits and holds miss_valid and byte_valid low. Consequently, the first symbol after reset is predicted only if it equals 0.
- R2: When the table entry addressed by the previous symbol equals the incoming symbol, the verdict bit is 1 and miss_valid stays low in the following cycle.
- R3: When that entry differs from the incoming symbol, the verdict bit is 0, and in the following cycle miss_valid is 1 and miss_idx carries the symbol.
- R4: On a miss, the addressed entry is overwritten with the symbol, so the same pair of previous and current symbol is predicted the next time it occurs.
- R5: The history takes every accepted symbol, whether it hit or missed. A cycle with in_valid low changes neither the history nor the table, and it produces no output.
- R6: Verdict bits fill a byte starting at bit 7, in order of arrival. In the cycle after the eighth bit, byte_valid is 1 for exactly one cycle with that byte on byte_data.
- R7: When flush is high with 1 to 7 pending bits, the next cycle emits those bits from bit 7 down, with the unused low bits set to 0. When flush is high with no pending bits, nothing is emitted.
- R8: A symbol accepted in the same cycle as flush is packed before the flush takes effect. If that symbol completes a byte, exactly one full byte is emitted.
- R9: One symbol is accepted on every clock with in_valid high, with no stall, and all outputs appear one cycle after acceptance.
- R10: A run of eight correctly predicted symbols produces the byte 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A symbol is presented this cycle |
| in_idx | input | 8 | Incoming stream cache index |
| flush | input | 1 | Emit any partly filled verdict byte |
| miss_valid | output | 1 | miss_idx holds a mispredicted symbol |
| miss_idx | output | 8 | Symbol that was not predicted |
| byte_valid | output | 1 | byte_data holds a packed verdict byte |
| byte_data | output | 8 | Verdict bits, first symbol in bit 7 |

## Verification
A corrupted table entry or history value shows up at the ports as a wrong verdict. It appears as an unexpected pulse, or a missing pulse, on miss_valid one cycle after the affected symbol, and it also changes a bit of the next packed byte. A packing fault, such as a wrong bit count, wrong order or wrong padding, only becomes visible when a byte leaves, which can be up to eight symbols later. For that reason, the stimulus walks sequences whose hit and miss pattern is known bit by bit, and it flushes at several fill levels. Idle cycles carry a value that would flip the next verdict if it leaked into the history. A reset applied with bits pending is followed by a flushed symbol, which exposes any bits or table entries that survived the reset.

// File: rtl/sidx_pred_pack.sv
module sidx_pred_pack #(
  parameter int IDX_W  = 8,
  parameter int PACK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic              flush,
  output logic              miss_valid,
  output logic [IDX_W-1:0]  miss_idx,
  output logic              byte_valid,
  output logic [PACK_W-1:0] byte_data
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CW    = $clog2(PACK_W + 1);

  logic [IDX_W-1:0]  hist;
  logic [IDX_W-1:0]  tbl [DEPTH];
  logic [PACK_W-1:0] acc;
  logic [CW-1:0]     cnt;

  logic              hit;
  logic [CW-1:0]     ncnt;
  logic [PACK_W-1:0] nacc;
  logic [CW-1:0]     pad;
  logic              full;
  logic              emit;

  assign hit  = (tbl[hist] == in_idx);
  assign ncnt = cnt + CW'(in_valid);
  assign nacc = in_valid ? {acc[PACK_W-2:0], hit} : acc;
  assign pad  = CW'(PACK_W) - ncnt;
  assign full = (ncnt == CW'(PACK_W));
  assign emit = full || (flush && ncnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (in_valid) begin
      hist <= in_idx;
      if (!hit) tbl[hist] <= in_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_valid <= 1'b0;
      miss_idx   <= '0;
    end else begin
      miss_valid <= in_valid && !hit;
      if (in_valid && !hit) miss_idx <= in_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      cnt        <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= emit;
      if (emit) begin
        byte_data <= nacc << pad;
        acc       <= '0;
        cnt       <= '0;
      end else begin
        acc <= nacc;
        cnt <= ncnt;
      end
    end
  end

  // R3
  miss_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> $past(in_valid));

  // R3
  miss_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> miss_idx == $past(in_idx));

  // R7
  byte_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(in_valid || flush));

  // R6
  fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(PACK_W));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) && !$past(flush) && $past(rst_n) |-> !miss_valid && !byte_valid);
endmodule

// File: tb/sidx_pred_pack_tb.sv
`timescale 1ns/1ps
module sidx_pred_pack_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_idx = '0;
  logic       flush = 1'b0;
  logic       miss_valid;
  logic [7:0] miss_idx;
  logic       byte_valid;
  logic [7:0] byte_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sidx_pred_pack dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_idx(in_idx), .flush(flush),
    .miss_valid(miss_valid), .miss_idx(miss_idx),
    .byte_valid(byte_valid), .byte_data(byte_data)
  );

  // {idx, flush, exp_miss, exp_byte_valid, exp_byte}
  localparam logic [18:0] VEC [16] = '{
    {8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h05, 1'b0, 1'b1, 1'b0, 8'h00},
    {8'h07, 1'b0, 1'b1, 1'b0, 8'h00},
    {8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h05, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h07, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h09, 1'b0, 1'b1, 1'b1, 8'h9E},
    {8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h09, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h09, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h09, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h00, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h09, 1'b0, 1'b0, 1'b1, 8'hFF}
  };

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] idx, input bit v, input bit fl,
                      input bit em, input bit ebv, input logic [7:0] eb, input string req);
    in_valid = v;
    in_idx   = idx;
    flush    = fl;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    flush    = 1'b0;
    check(miss_valid == em, {req, " miss_valid"}, 8'(miss_valid), 8'(em));
    if (em) check(miss_idx == idx, {req, " miss_idx"}, miss_idx, idx);
    check(byte_valid == ebv, {req, " byte_valid"}, 8'(byte_valid), 8'(ebv));
    if (ebv) check(byte_data == eb, {req, " byte_data"}, byte_data, eb);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    check(!miss_valid && !byte_valid, "R1 reset outputs", {6'b0, miss_valid, byte_valid}, 8'h00);
    rst_n = 1'b1;

    // R2 R3 R4 R6 R9 R10: back-to-back vectors
    for (int i = 0; i < 16; i++) begin
      step(VEC[i][18:11], 1'b1, VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0],
           (i == 15) ? "R10 run" : (i == 7) ? "R6 pack" : "R2 R3 R4 vec");
    end

    // R7: partial byte 100 -> 0x80, then empty flush
    step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R2 d1");
    step(8'h03, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R3 d1");
    step(8'h09, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R3 d1b");
    step(8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h80, "R7 partial");
    step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7 empty flush");

    // R5: idle cycle with a value that would change the next verdict
    step(8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R5 idle");
    step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R5 history kept");

    // R8: flush together with the symbol that completes a byte
    step(8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8 a");
    step(8'h09, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8 b");
    step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8 c");
    step(8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8 d");
    step(8'h09, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8 e");
    step(8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8 f");
    step(8'h03, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, "R8 full with flush");
    step(8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R8 nothing left");

    // R8 R7: single symbol with flush, hit then miss
    step(8'h09, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80, "R8 hit flushed");
    step(8'h05, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R8 miss flushed");

    // R1: reset with a pending bit, then table and packer must be clean
    step(8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R3 before reset");
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!miss_valid && !byte_valid, "R1 mid reset", {6'b0, miss_valid, byte_valid}, 8'h00);
    rst_n = 1'b1;
    step(8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80, "R1 clean after reset");
    step(8'h05, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, "R1 table zero");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule